// File: doc/BRIEF.md
# RV64 Word and Shift Execute Unit

This block is one registered execute stage of a 64-bit RISC-V pipeline. It handles two groups of instructions. The first group is the 64-bit shifts by an immediate. The second group is the 32-bit "word" operations: add-immediate-word, the word shifts by an immediate, and the add, subtract and shift word operations between two registers. Each cycle the issuing stage presents an instruction word, the two source operand values and a valid strobe. One clock edge later the block returns the 64-bit result, the destination register index, a write enable for the register file and a flag for an encoding it refuses.

Word operations work only on the low 32 bits of their operands. Their 32-bit result is sign-extended to fill the 64-bit destination. A 64-bit shift takes a six-bit amount. A word shift uses only five bits: from the immediate field, or from the low five bits of the second register. Encodings that are reserved or outside this group raise the illegal flag and never write a register.

Top module: `word_shift_alu`

## Requirements
- R1: Every output is registered. The result, rd index, write enable and illegal flag for an instruction presented with `validIn` high appear after the next rising clock edge. In any cycle that follows a cycle with `validIn` low, `weOut` and `illegalOut` are both 0.
- R2: Opcode 0010011 with funct3 001 and bits 31:26 equal to 000000 shifts `rs1In` left logically by the six-bit amount in bits 25:20.
- R3: Opcode 0010011 with funct3 101 shifts `rs1In` right by the six-bit amount in bits 25:20. The shift is logical when bits 31:26 are 000000 and arithmetic when they are 010000.
- R4: For opcode 0010011 shifts, any other value of bits 31:26 raises `illegalOut` and keeps `weOut` low. Any other funct3 on that opcode is also illegal.
- R5: Opcode 0011011 with funct3 000 adds the sign-extended 12-bit immediate in bits 31:20 to the low 32 bits of `rs1In`. The 32-bit sum is sign-extended to 64 bits.
- R6: Opcode 0011011 shifts the low 32 bits of `rs1In` by the five-bit amount in bits 24:20. Funct3 001 with bits 31:25 = 0000000 is a left shift. Funct3 101 is a logical right shift with bits 31:25 = 0000000 and an arithmetic right shift, on the signed low word, with 0100000. The 32-bit result is sign-extended.
- R7: Opcode 0111011 with funct3 000 adds the low words of `rs1In` and `rs2In` when bits 31:25 = 0000000. It subtracts the low word of `rs2In` from that of `rs1In` when they are 0100000. The 32-bit result wraps and is sign-extended.
- R8: Opcode 0111011 with funct3 001 (left), or with funct3 101 (logical right for 0000000, arithmetic right for 0100000), shifts the low word of `rs1In` by `rs2In` ANDed with 0x1F. The 32-bit result is sign-extended.
- R9: A legal instruction whose rd field (bits 11:7) is 0 leaves `weOut` low and `illegalOut` low.
- R10: Word operations with a reserved value in bits 31:25, any funct3 not listed above, and any other opcode raise `illegalOut` with `weOut` low. A legal instruction with a nonzero rd raises `weOut` with `illegalOut` low. `rdOut` carries bits 11:7 of the instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Instruction and operands are present this cycle |
| instrIn | input | 32 | Instruction word |
| rs1In | input | XLEN | First source operand value |
| rs2In | input | XLEN | Second source operand value |
| resultOut | output | XLEN | Registered result |
| rdOut | output | 5 | Registered destination register index |
| weOut | output | 1 | Registered register-file write enable |
| illegalOut | output | 1 | Registered flag for a refused encoding |

## Verification
The bench builds the block with its default XLEN of 64, so the word width is 32. At that size every shift amount can be swept completely: all 64 amounts for each 64-bit shift kind, and all 32 amounts for each word shift kind, in both the immediate form and the register form. The register-form sweeps use `rs2In` values with their upper bits set, which makes the five-bit mask visible. The add and subtract cases are chosen to cross the 32-bit carry and sign boundaries. The reserved encodings are each presented once.

// File: rtl/wsa_pkg.sv
package wsa_pkg;

  localparam logic [6:0] OPC_SHIFT64 = 7'b0010011;
  localparam logic [6:0] OPC_IMMWORD = 7'b0011011;
  localparam logic [6:0] OPC_REGWORD = 7'b0111011;

  localparam logic [2:0] F3_ADDSUB = 3'b000;
  localparam logic [2:0] F3_LEFT   = 3'b001;
  localparam logic [2:0] F3_RIGHT  = 3'b101;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;
  localparam logic [5:0] F6_BASE = 6'b000000;
  localparam logic [5:0] F6_ALT  = 6'b010000;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic wordOp;
    logic useImm;
    logic subtract;
    logic isShift;
    logic shLeft;
    logic shArith;
  } strobe_t;

endpackage

// File: rtl/wsa_shifter.sv
module wsa_shifter #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0]         dataIn,
  input  logic [$clog2(WIDTH)-1:0] amount,
  input  logic                     shiftLeft,
  input  logic                     arith,
  output logic [WIDTH-1:0]         dataOut
);
  localparam int STAGES = $clog2(WIDTH);

  logic [WIDTH-1:0] reversedIn;
  logic [WIDTH-1:0] source;
  logic [WIDTH-1:0] reversedOut;
  logic             fillBit;
  logic [WIDTH-1:0] stage [STAGES+1];

  // left shift = reverse, right shift, reverse
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      reversedIn[i] = dataIn[WIDTH-1-i];
    end
  end

  assign source   = shiftLeft ? reversedIn : dataIn;
  assign fillBit  = arith & ~shiftLeft & dataIn[WIDTH-1];
  assign stage[0] = source;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int SPAN = 1 << k;
    assign stage[k+1] = amount[k] ? {{SPAN{fillBit}}, stage[k][WIDTH-1:SPAN]}
                                  : stage[k];
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      reversedOut[i] = stage[STAGES][WIDTH-1-i];
    end
  end

  assign dataOut = shiftLeft ? reversedOut : stage[STAGES];
endmodule

// File: rtl/wsa_control.sv
module wsa_control
  import wsa_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic [31:0] instrIn,
  output strobe_t     strobes,
  output logic [4:0]  rdOut,
  output logic        weOut,
  output logic        illegalOut
);
  logic [6:0] opcode;
  logic [2:0] funct3;
  logic [6:0] funct7;
  logic [5:0] funct6;
  logic [4:0] rdIdx;
  logic       legal;

  assign opcode = instrIn[6:0];
  assign funct3 = instrIn[14:12];
  assign funct7 = instrIn[31:25];
  assign funct6 = instrIn[31:26];
  assign rdIdx  = instrIn[11:7];

  always_comb begin
    strobes         = '0;
    strobes.capture = validIn;
    legal           = 1'b0;
    unique case (opcode)
      OPC_SHIFT64: begin
        strobes.useImm  = 1'b1;
        strobes.isShift = 1'b1;
        if (funct3 == F3_LEFT && funct6 == F6_BASE) begin
          legal          = 1'b1;
          strobes.shLeft = 1'b1;
        end else if (funct3 == F3_RIGHT && (funct6 == F6_BASE || funct6 == F6_ALT)) begin
          legal           = 1'b1;
          strobes.shArith = (funct6 == F6_ALT);
        end
      end
      OPC_IMMWORD: begin
        strobes.wordOp = 1'b1;
        strobes.useImm = 1'b1;
        if (funct3 == F3_ADDSUB) begin
          legal = 1'b1;
        end else if (funct3 == F3_LEFT && funct7 == F7_BASE) begin
          legal           = 1'b1;
          strobes.isShift = 1'b1;
          strobes.shLeft  = 1'b1;
        end else if (funct3 == F3_RIGHT && (funct7 == F7_BASE || funct7 == F7_ALT)) begin
          legal           = 1'b1;
          strobes.isShift = 1'b1;
          strobes.shArith = (funct7 == F7_ALT);
        end
      end
      OPC_REGWORD: begin
        strobes.wordOp = 1'b1;
        if (funct3 == F3_ADDSUB && (funct7 == F7_BASE || funct7 == F7_ALT)) begin
          legal            = 1'b1;
          strobes.subtract = (funct7 == F7_ALT);
        end else if (funct3 == F3_LEFT && funct7 == F7_BASE) begin
          legal           = 1'b1;
          strobes.isShift = 1'b1;
          strobes.shLeft  = 1'b1;
        end else if (funct3 == F3_RIGHT && (funct7 == F7_BASE || funct7 == F7_ALT)) begin
          legal           = 1'b1;
          strobes.isShift = 1'b1;
          strobes.shArith = (funct7 == F7_ALT);
        end
      end
      default: legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weOut      <= 1'b0;
      illegalOut <= 1'b0;
      rdOut      <= '0;
    end else begin
      weOut      <= validIn & legal & (rdIdx != 5'd0);
      illegalOut <= validIn & ~legal;
      if (validIn) rdOut <= rdIdx;
    end
  end
endmodule

// File: rtl/wsa_datapath.sv
module wsa_datapath
  import wsa_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobes,
  input  logic [31:0]     instrIn,
  input  logic [XLEN-1:0] rs1In,
  input  logic [XLEN-1:0] rs2In,
  output logic [XLEN-1:0] resultOut
);
  localparam int WLEN    = XLEN / 2;
  localparam int SHW     = $clog2(XLEN);
  localparam int WSHW    = $clog2(WLEN);
  localparam int IMMBITS = 12;

  logic [XLEN-1:0] immValue;
  logic [XLEN-1:0] operandB;
  logic [WLEN-1:0] lowA;
  logic [WLEN-1:0] lowB;
  logic [WLEN-1:0] wordSum;
  logic [WLEN-1:0] wordShift;
  logic [WLEN-1:0] wordResult;
  logic [XLEN-1:0] fullShift;
  logic [XLEN-1:0] nextResult;

  assign immValue = {{(XLEN-IMMBITS){instrIn[31]}}, instrIn[31:20]};
  assign operandB = strobes.useImm ? immValue : rs2In;
  assign lowA     = rs1In[WLEN-1:0];
  assign lowB     = operandB[WLEN-1:0];

  assign wordSum = strobes.subtract ? (lowA - lowB) : (lowA + lowB);

  wsa_shifter #(.WIDTH(XLEN)) u_shift64 (
    .dataIn   (rs1In),
    .amount   (operandB[SHW-1:0]),
    .shiftLeft(strobes.shLeft),
    .arith    (strobes.shArith),
    .dataOut  (fullShift)
  );

  // word width shifter: amount field is WSHW bits, so masking is implicit
  wsa_shifter #(.WIDTH(WLEN)) u_shift32 (
    .dataIn   (lowA),
    .amount   (operandB[WSHW-1:0]),
    .shiftLeft(strobes.shLeft),
    .arith    (strobes.shArith),
    .dataOut  (wordShift)
  );

  assign wordResult = strobes.isShift ? wordShift : wordSum;
  assign nextResult = strobes.wordOp ? {{(XLEN-WLEN){wordResult[WLEN-1]}}, wordResult}
                                     : fullShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultOut <= '0;
    end else if (strobes.capture) begin
      resultOut <= nextResult;
    end
  end
endmodule

// File: rtl/word_shift_alu.sv
module word_shift_alu
  import wsa_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            validIn,
  input  logic [31:0]     instrIn,
  input  logic [XLEN-1:0] rs1In,
  input  logic [XLEN-1:0] rs2In,
  output logic [XLEN-1:0] resultOut,
  output logic [4:0]      rdOut,
  output logic            weOut,
  output logic            illegalOut
);
  strobe_t strobes;

  wsa_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .instrIn   (instrIn),
    .strobes   (strobes),
    .rdOut     (rdOut),
    .weOut     (weOut),
    .illegalOut(illegalOut)
  );

  wsa_datapath #(.XLEN(XLEN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .instrIn  (instrIn),
    .rs1In    (rs1In),
    .rs2In    (rs2In),
    .resultOut(resultOut)
  );
endmodule

// File: rtl/wsa_checker.sv
module wsa_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            validIn,
  input logic [31:0]     instrIn,
  input logic [XLEN-1:0] rs1In,
  input logic [XLEN-1:0] rs2In,
  input logic [XLEN-1:0] resultOut,
  input logic [4:0]      rdOut,
  input logic            weOut,
  input logic            illegalOut
);
  localparam int WLEN = XLEN / 2;

  logic isWordOpc;
  logic badShift64;
  logic isSubw;
  assign isWordOpc  = (instrIn[6:0] == 7'b0011011) || (instrIn[6:0] == 7'b0111011);
  assign badShift64 = (instrIn[6:0] == 7'b0010011) && (instrIn[14:12] == 3'b001)
                      && (instrIn[31:26] != 6'b000000);
  assign isSubw     = (instrIn[6:0] == 7'b0111011) && (instrIn[14:12] == 3'b000)
                      && (instrIn[31:25] == 7'b0100000) && (instrIn[11:7] != 5'd0);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> (!weOut && !illegalOut));

  p_shift_reserved_r4: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && badShift64) |=> (illegalOut && !weOut));

  p_word_sext_r5: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && isWordOpc) |=>
      (!weOut || resultOut[XLEN-1:WLEN-1] == '0 || resultOut[XLEN-1:WLEN-1] == '1));

  p_subw_value_r7: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && isSubw) |=>
      (weOut && resultOut[WLEN-1:0] == ($past(rs1In[WLEN-1:0]) - $past(rs2In[WLEN-1:0]))));

  p_rd_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && instrIn[11:7] == 5'd0) |=> !weOut);

  p_we_ill_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(weOut && illegalOut));

  p_rd_follows_r10: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> (rdOut == $past(instrIn[11:7])));
endmodule

bind word_shift_alu wsa_checker #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .validIn   (validIn),
  .instrIn   (instrIn),
  .rs1In     (rs1In),
  .rs2In     (rs2In),
  .resultOut (resultOut),
  .rdOut     (rdOut),
  .weOut     (weOut),
  .illegalOut(illegalOut)
);

// File: tb/word_shift_alu_tb.sv
module word_shift_alu_tb;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            validIn = 1'b0;
  logic [31:0]     instrIn = '0;
  logic [XLEN-1:0] rs1In = '0;
  logic [XLEN-1:0] rs2In = '0;
  logic [XLEN-1:0] resultOut;
  logic [4:0]      rdOut;
  logic            weOut;
  logic            illegalOut;

  int testCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  word_shift_alu #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .instrIn(instrIn),
    .rs1In(rs1In), .rs2In(rs2In), .resultOut(resultOut), .rdOut(rdOut),
    .weOut(weOut), .illegalOut(illegalOut)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sx32(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic [31:0] rtype(input logic [6:0] f7, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] opc);
    return {f7, 5'd2, 5'd1, f3, rd, opc};
  endfunction

  function automatic logic [31:0] itype(input logic [11:0] imm, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] opc);
    return {imm, 5'd1, f3, rd, opc};
  endfunction

  // present one instruction, then sample outputs after the capturing edge
  task automatic run(input string req, input logic [31:0] ins, input logic [63:0] a,
                     input logic [63:0] b, input logic expLegal, input logic [63:0] expRes);
    logic [4:0] rd;
    rd = ins[11:7];
    @(negedge clk);
    instrIn = ins; rs1In = a; rs2In = b; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    check({req, " illegal"}, {63'd0, illegalOut}, {63'd0, !expLegal});
    check({req, " we"}, {63'd0, weOut}, {63'd0, expLegal && rd != 5'd0});
    if (expLegal) begin
      check({req, " rd"}, {59'd0, rdOut}, {59'd0, rd});
      check({req, " result"}, resultOut, expRes);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failCount++;
    testCount++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [63:0] a64;
    logic [31:0] w;
    logic [63:0] b;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset we", {63'd0, weOut}, 64'd0);
    check("R1 reset ill", {63'd0, illegalOut}, 64'd0);
    check("R1 reset result", resultOut, 64'd0);
    rstN = 1'b1;

    // R2 R3 64-bit immediate shifts, every amount
    for (int pat = 0; pat < 2; pat++) begin
      a64 = (pat == 0) ? 64'h8123_4567_89AB_CDEF : 64'h7FED_CBA9_8765_4321;
      for (int s = 0; s < 64; s++) begin
        run("R2 slli", {6'b000000, s[5:0], 5'd1, 3'b001, 5'd5, 7'b0010011}, a64, '0, 1'b1, a64 << s);
        run("R3 srli", {6'b000000, s[5:0], 5'd1, 3'b101, 5'd6, 7'b0010011}, a64, '0, 1'b1, a64 >> s);
        run("R3 srai", {6'b010000, s[5:0], 5'd1, 3'b101, 5'd7, 7'b0010011}, a64, '0, 1'b1,
            64'($signed(a64) >>> s));
      end
    end

    // R6 R8 word shifts, every amount, immediate and register forms
    for (int pat = 0; pat < 2; pat++) begin
      a64 = (pat == 0) ? 64'h1234_5678_8000_00F1 : 64'hFFFF_0000_7654_3210;
      w = a64[31:0];
      for (int s = 0; s < 32; s++) begin
        b = {32'hABCD_EF00, 24'h0, 3'b111, s[4:0]};
        run("R6 slliw", {7'b0000000, s[4:0], 5'd1, 3'b001, 5'd8, 7'b0011011}, a64, '0, 1'b1, sx32(w << s));
        run("R6 srliw", {7'b0000000, s[4:0], 5'd1, 3'b101, 5'd9, 7'b0011011}, a64, '0, 1'b1, sx32(w >> s));
        run("R6 sraiw", {7'b0100000, s[4:0], 5'd1, 3'b101, 5'd10, 7'b0011011}, a64, '0, 1'b1,
            sx32(32'($signed(w) >>> s)));
        run("R8 sllw", rtype(7'b0000000, 3'b001, 5'd11, 7'b0111011), a64, b, 1'b1, sx32(w << (b & 31)));
        run("R8 srlw", rtype(7'b0000000, 3'b101, 5'd12, 7'b0111011), a64, b, 1'b1, sx32(w >> (b & 31)));
        run("R8 sraw", rtype(7'b0100000, 3'b101, 5'd13, 7'b0111011), a64, b, 1'b1,
            sx32(32'($signed(w) >>> (b & 31))));
      end
    end

    // R5 add-immediate-word
    run("R5 addiw wrap", itype(12'h001, 3'b000, 5'd3, 7'b0011011), 64'h0000_0001_7FFF_FFFF, '0, 1'b1,
        64'hFFFF_FFFF_8000_0000);
    run("R5 addiw neg", itype(12'hFFF, 3'b000, 5'd3, 7'b0011011), 64'h1234_5678_0000_0000, '0, 1'b1,
        64'hFFFF_FFFF_FFFF_FFFF);
    run("R5 addiw pos", itype(12'h7FF, 3'b000, 5'd4, 7'b0011011), 64'hFFFF_FFFF_0000_0100, '0, 1'b1,
        64'h0000_0000_0000_08FF);

    // R7 add and subtract word
    run("R7 addw carry", rtype(7'b0000000, 3'b000, 5'd14, 7'b0111011), 64'hAAAA_AAAA_FFFF_FFFF,
        64'h5555_5555_0000_0002, 1'b1, 64'h0000_0000_0000_0001);
    run("R7 addw sign", rtype(7'b0000000, 3'b000, 5'd14, 7'b0111011), 64'h0000_0000_4000_0000,
        64'h0000_0000_4000_0000, 1'b1, 64'hFFFF_FFFF_8000_0000);
    run("R7 subw borrow", rtype(7'b0100000, 3'b000, 5'd15, 7'b0111011), 64'h0000_0000_0000_0000,
        64'hFFFF_FFFF_0000_0001, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R7 subw pos", rtype(7'b0100000, 3'b000, 5'd15, 7'b0111011), 64'h0000_0000_8000_0000,
        64'h0000_0000_0000_0001, 1'b1, 64'h0000_0000_7FFF_FFFF);

    // R9 rd zero
    run("R9 addw rd0", rtype(7'b0000000, 3'b000, 5'd0, 7'b0111011), 64'd5, 64'd6, 1'b1, 64'd11);
    run("R9 slli rd0", {6'b000000, 6'd3, 5'd1, 3'b001, 5'd0, 7'b0010011}, 64'd1, '0, 1'b1, 64'd8);

    // R4 R10 reserved encodings
    run("R4 slli bad f6", {6'b000001, 6'd3, 5'd1, 3'b001, 5'd5, 7'b0010011}, 64'd1, '0, 1'b0, '0);
    run("R4 srli bad f6", {6'b100000, 6'd3, 5'd1, 3'b101, 5'd5, 7'b0010011}, 64'd1, '0, 1'b0, '0);
    run("R4 other f3", itype(12'h010, 3'b000, 5'd5, 7'b0010011), 64'd1, '0, 1'b0, '0);
    run("R10 slliw bit25", {7'b0000001, 5'd3, 5'd1, 3'b001, 5'd5, 7'b0011011}, 64'd1, '0, 1'b0, '0);
    run("R10 addw bad f7", rtype(7'b0000001, 3'b000, 5'd5, 7'b0111011), 64'd1, 64'd1, 1'b0, '0);
    run("R10 sllw alt f7", rtype(7'b0100000, 3'b001, 5'd5, 7'b0111011), 64'd1, 64'd1, 1'b0, '0);
    run("R10 word f3 010", rtype(7'b0000000, 3'b010, 5'd5, 7'b0111011), 64'd1, 64'd1, 1'b0, '0);
    run("R10 other opcode", rtype(7'b0000000, 3'b000, 5'd5, 7'b0110011), 64'd1, 64'd1, 1'b0, '0);

    // R1 idle cycle after activity
    @(negedge clk);
    check("R1 idle we", {63'd0, weOut}, 64'd0);
    check("R1 idle ill", {63'd0, illegalOut}, 64'd0);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule